// File: doc/BRIEF.md
# Dual-Port Byte-Write Synchronous RAM

This block is a memory of 16-bit words with two independent ports. Each port has its own clock, and either port can read or write any location while the other port is active. Every port input is captured on the rising edge of that port's clock: the address, the write data, the two chip enables, the read/write select and the two active-low byte selects. A write updates only the byte lanes that are selected. A read drives only the selected lanes, and only while the asynchronous output enable is low.

Each port has a static mode input that sets the read latency. In flow-through mode, read data appears in the cycle after the sampling edge. In pipelined mode it appears one cycle later. In pipelined mode the chip-enable decision is also delayed, so a port keeps driving for one extra cycle after it is deselected. The byte selects are captured by a single register in both modes. The three-state data pins are modelled as a data word plus one drive flag per byte; a byte that is not driven reads as zero.

The storage is a pair of banks, one written by each port. For each byte, a pair of tag bits records which port wrote it last, so each storage element has only one writer.

Top module: `dpram_bw`

## Requirements
- R1: A port is selected only when its ce0_n is 0 and its ce1 is 1. A deselected port writes nothing and drives nothing.
- R2: A selected port with rd_nwr = 0 writes only the lanes whose select is 0 (up_n controls bits 15:8, lo_n controls bits 7:0). Unselected lanes keep their old contents.
- R3: A selected read drives a lane only if that lane's select is 0. drive[1] flags bits 15:8 and drive[0] flags bits 7:0. An undriven lane reads as 0 on dout.
- R4: With up_n = lo_n = 1, nothing is written and nothing is driven, even when the port is selected.
- R5: When oe_n = 1, drive is 0 and dout is 0 at once, with no clock edge needed. Driving resumes when oe_n returns to 0.
- R6: In flow-through mode (pipe = 0), a read sampled at edge k drives its data after edge k.
- R7: In pipelined mode (pipe = 1), a read sampled at edge k drives nothing after edge k and drives its data after edge k+1.
- R8: In pipelined mode, a port deselected at edge k+1 still drives the read sampled at edge k until edge k+2. In flow-through mode, drive stops right after the deselecting edge.
- R9: The byte selects are captured by a single register in both modes. In pipelined mode, the lanes driven after edge k+1 are those selected at edge k+1.
- R10: Either port can write a word that the other port later reads back unchanged, at any address including 0 and the top address.
- R11: A port that writes at edge k and reads the same address at edge k+1 gets the new data.
- R12: While reset is asserted, both ports drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the port pipelines |
| a_clk | input | 1 | Port A clock |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_rd_nwr | input | 1 | Port A: 1 = read, 0 = write |
| a_up_n | input | 1 | Port A upper-lane select, active low |
| a_lo_n | input | 1 | Port A lower-lane select, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A latency mode: 1 = pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | 16 | Port A write data |
| a_dout | output | 16 | Port A read data; undriven lanes are 0 |
| a_drive | output | 2 | Port A per-lane drive flags |
| b_clk | input | 1 | Port B clock |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_rd_nwr | input | 1 | Port B: 1 = read, 0 = write |
| b_up_n | input | 1 | Port B upper-lane select, active low |
| b_lo_n | input | 1 | Port B lower-lane select, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B latency mode: 1 = pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | 16 | Port B write data |
| b_dout | output | 16 | Port B read data; undriven lanes are 0 |
| b_drive | output | 2 | Port B per-lane drive flags |

## Verification
Writes alternate between the ports, and each write is read back on the other port. The writes use full, upper-only and lower-only lane masks. This separates a lane mask that leaks into the neighbouring byte from a lane-ownership tag that picks the wrong bank. Directed sequences hold the enables in partly-asserted patterns and both lane selects high. These show whether a write happens or a drive appears when it should not. Pipelined reads followed by a deselect, or by a change of lane select, show the two-stage chip-enable path apart from the single-stage byte-select path. A toggle of the output enable between clock edges confirms that it acts without a clock.

// File: rtl/dpram_bw_pkg.sv
package dpram_bw_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lane_t;
  typedef logic [WORD_W-1:0] word_t;

  // Port selection: active-low enable low and active-high enable high.
  function automatic logic port_sel(input logic ce0_n, input logic ce1);
    return !ce0_n && ce1;
  endfunction

  // Active-low lane pins to an active-high lane vector, upper lane at bit 1.
  function automatic lane_t lanes_from(input logic up_n, input logic lo_n);
    return {!up_n, !lo_n};
  endfunction

  // Zero every lane that is not flagged.
  function automatic word_t lane_mask(input word_t w, input lane_t l);
    word_t m;
    for (int i = 0; i < LANES; i++)
      m[i*LANE_W +: LANE_W] = l[i] ? w[i*LANE_W +: LANE_W] : '0;
    return m;
  endfunction
endpackage

// File: rtl/dpram_bw_bank.sv
module dpram_bw_bank
  import dpram_bw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_a,
  input  lane_t             wr_lanes_a,
  input  logic [ADDR_W-1:0] wr_addr_a,
  input  word_t             wr_data_a,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output word_t             rd_word_a,
  input  logic              clk_b,
  input  lane_t             wr_lanes_b,
  input  logic [ADDR_W-1:0] wr_addr_b,
  input  word_t             wr_data_b,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output word_t             rd_word_b
);
  localparam int DEPTH = 1 << ADDR_W;

  // One bank per port and lane, each with a single writer. The XOR of the
  // two tag bits tells which bank holds the newest byte: 1 selects bank A.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank_a [DEPTH];
    logic [LANE_W-1:0] bank_b [DEPTH];
    logic              tag_a  [DEPTH];
    logic              tag_b  [DEPTH];

    always_ff @(posedge clk_a) begin
      if (wr_lanes_a[g]) begin
        bank_a[wr_addr_a] <= wr_data_a[g*LANE_W +: LANE_W];
        tag_a[wr_addr_a]  <= !tag_b[wr_addr_a];
      end
    end

    always_ff @(posedge clk_b) begin
      if (wr_lanes_b[g]) begin
        bank_b[wr_addr_b] <= wr_data_b[g*LANE_W +: LANE_W];
        tag_b[wr_addr_b]  <= tag_a[wr_addr_b];
      end
    end

    logic own_a_at_a, own_a_at_b;
    assign own_a_at_a = tag_a[rd_addr_a] ^ tag_b[rd_addr_a];
    assign own_a_at_b = tag_a[rd_addr_b] ^ tag_b[rd_addr_b];
    assign rd_word_a[g*LANE_W +: LANE_W] = own_a_at_a ? bank_a[rd_addr_a] : bank_b[rd_addr_a];
    assign rd_word_b[g*LANE_W +: LANE_W] = own_a_at_b ? bank_a[rd_addr_b] : bank_b[rd_addr_b];
  end
endmodule

// File: rtl/dpram_bw_port.sv
module dpram_bw_port
  import dpram_bw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              rd_nwr,
  input  logic              up_n,
  input  logic              lo_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             din,
  output lane_t             wr_lanes,
  output logic [ADDR_W-1:0] wr_addr,
  output word_t             wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  word_t             rd_word,
  output word_t             dout,
  output lane_t             drive
);
  logic              sel_q, rnw_q, rd_q2;
  lane_t             lanes_q;
  logic [ADDR_W-1:0] addr_q;
  word_t             din_q, pdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      rnw_q   <= 1'b1;
      rd_q2   <= 1'b0;
      lanes_q <= '0;
      addr_q  <= '0;
      din_q   <= '0;
      pdat_q  <= '0;
    end else begin
      sel_q   <= port_sel(ce0_n, ce1);
      rnw_q   <= rd_nwr;
      lanes_q <= lanes_from(up_n, lo_n);
      addr_q  <= addr;
      din_q   <= din;
      rd_q2   <= sel_q && rnw_q;   // second chip-enable stage
      pdat_q  <= rd_word;          // output register for pipelined mode
    end
  end

  // Named internal events
  logic  rd_stage1, rd_live, wr_fire;
  lane_t out_lanes;
  word_t data_src;

  assign rd_stage1 = sel_q && rnw_q;
  assign rd_live   = pipe ? rd_q2 : rd_stage1;
  assign out_lanes = lanes_q & {LANES{rd_live && !oe_n}};
  assign data_src  = pipe ? pdat_q : rd_word;
  assign wr_lanes  = lanes_q & {LANES{sel_q && !rnw_q}};
  assign wr_fire   = |wr_lanes;

  assign wr_addr = addr_q;
  assign wr_data = din_q;
  assign rd_addr = addr_q;
  assign dout    = lane_mask(data_src, out_lanes);
  assign drive   = out_lanes;

  // R1 / R2: a write only follows a selected write request
  assert_write_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(!ce0_n && ce1 && !rd_nwr));

  // R9: each driven lane was selected at the previous edge, in either mode
  assert_upper_lane_single_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drive[1] |-> $past(!up_n));

  assert_lower_lane_single_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drive[0] |-> $past(!lo_n));

  // R6: flow-through drive comes from the read sampled one edge back
  assert_flow_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && drive != '0) |-> $past(!ce0_n && ce1 && rd_nwr));

  // R7 / R8: pipelined drive comes from the read sampled two edges back
  assert_pipe_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && drive != '0) |-> $past(!ce0_n && ce1 && rd_nwr, 2));
endmodule

// File: rtl/dpram_bw.sv
module dpram_bw
  import dpram_bw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_ce0_n,
  input  logic              a_ce1,
  input  logic              a_rd_nwr,
  input  logic              a_up_n,
  input  logic              a_lo_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [15:0]       a_din,
  output logic [15:0]       a_dout,
  output logic [1:0]        a_drive,
  input  logic              b_clk,
  input  logic              b_ce0_n,
  input  logic              b_ce1,
  input  logic              b_rd_nwr,
  input  logic              b_up_n,
  input  logic              b_lo_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [15:0]       b_din,
  output logic [15:0]       b_dout,
  output logic [1:0]        b_drive
);
  lane_t             wl_a, wl_b;
  logic [ADDR_W-1:0] wa_a, wa_b, ra_a, ra_b;
  word_t             wd_a, wd_b, rw_a, rw_b;

  dpram_bw_port #(.ADDR_W(ADDR_W)) u_port_a (
    .clk(a_clk), .rst_n(rst_n), .ce0_n(a_ce0_n), .ce1(a_ce1), .rd_nwr(a_rd_nwr),
    .up_n(a_up_n), .lo_n(a_lo_n), .oe_n(a_oe_n), .pipe(a_pipe), .addr(a_addr),
    .din(a_din), .wr_lanes(wl_a), .wr_addr(wa_a), .wr_data(wd_a), .rd_addr(ra_a),
    .rd_word(rw_a), .dout(a_dout), .drive(a_drive)
  );

  dpram_bw_port #(.ADDR_W(ADDR_W)) u_port_b (
    .clk(b_clk), .rst_n(rst_n), .ce0_n(b_ce0_n), .ce1(b_ce1), .rd_nwr(b_rd_nwr),
    .up_n(b_up_n), .lo_n(b_lo_n), .oe_n(b_oe_n), .pipe(b_pipe), .addr(b_addr),
    .din(b_din), .wr_lanes(wl_b), .wr_addr(wa_b), .wr_data(wd_b), .rd_addr(ra_b),
    .rd_word(rw_b), .dout(b_dout), .drive(b_drive)
  );

  dpram_bw_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk_a(a_clk), .wr_lanes_a(wl_a), .wr_addr_a(wa_a), .wr_data_a(wd_a),
    .rd_addr_a(ra_a), .rd_word_a(rw_a),
    .clk_b(b_clk), .wr_lanes_b(wl_b), .wr_addr_b(wa_b), .wr_data_b(wd_b),
    .rd_addr_b(ra_b), .rd_word_b(rw_b)
  );
endmodule

// File: tb/dpram_bw_test.sv
module dpram_bw_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic       a_ce0_n = 1'b1, a_ce1 = 1'b0, a_rd_nwr = 1'b1, a_up_n = 1'b1, a_lo_n = 1'b1;
  logic       a_oe_n = 1'b0, a_pipe = 1'b0;
  logic [7:0] a_addr = '0;
  logic [15:0] a_din = '0, a_dout;
  logic [1:0] a_drive;
  logic       b_ce0_n = 1'b1, b_ce1 = 1'b0, b_rd_nwr = 1'b1, b_up_n = 1'b1, b_lo_n = 1'b1;
  logic       b_oe_n = 1'b0, b_pipe = 1'b0;
  logic [7:0] b_addr = '0;
  logic [15:0] b_din = '0, b_dout;
  logic [1:0] b_drive;

  dpram_bw #(.ADDR_W(8)) uut (
    .rst_n(rst_n),
    .a_clk(clk), .a_ce0_n(a_ce0_n), .a_ce1(a_ce1), .a_rd_nwr(a_rd_nwr), .a_up_n(a_up_n),
    .a_lo_n(a_lo_n), .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_addr(a_addr), .a_din(a_din),
    .a_dout(a_dout), .a_drive(a_drive),
    .b_clk(clk), .b_ce0_n(b_ce0_n), .b_ce1(b_ce1), .b_rd_nwr(b_rd_nwr), .b_up_n(b_up_n),
    .b_lo_n(b_lo_n), .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_addr(b_addr), .b_din(b_din),
    .b_dout(b_dout), .b_drive(b_drive)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_a(input logic c0n, input logic c1, input logic rnw, input logic un,
                       input logic ln, input logic [7:0] ad, input logic [15:0] d);
    a_ce0_n = c0n; a_ce1 = c1; a_rd_nwr = rnw; a_up_n = un; a_lo_n = ln; a_addr = ad; a_din = d;
  endtask

  task automatic set_b(input logic c0n, input logic c1, input logic rnw, input logic un,
                       input logic ln, input logic [7:0] ad, input logic [15:0] d);
    b_ce0_n = c0n; b_ce1 = c1; b_rd_nwr = rnw; b_up_n = un; b_lo_n = ln; b_addr = ad; b_din = d;
  endtask

  // {addr, write data, up_n, lo_n, expected full-word read-back}
  localparam logic [41:0] VEC [8] = '{
    {8'h10, 16'h1234, 1'b0, 1'b0, 16'h1234},
    {8'h10, 16'hABCD, 1'b0, 1'b1, 16'hAB34},
    {8'h10, 16'h5566, 1'b1, 1'b0, 16'hAB66},
    {8'h20, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF},
    {8'h20, 16'h0000, 1'b1, 1'b0, 16'hFF00},
    {8'hFF, 16'h8001, 1'b0, 1'b0, 16'h8001},
    {8'h00, 16'h7E7E, 1'b0, 1'b0, 16'h7E7E},
    {8'h00, 16'h1111, 1'b0, 1'b1, 16'h117E}
  };

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R12: nothing driven during reset
    tick; tick;
    check("R12 a_drive in reset", {14'b0, a_drive}, 16'h0);
    check("R12 b_drive in reset", {14'b0, b_drive}, 16'h0);
    rst_n = 1'b1;
    tick;

    // Table: write on one port, read back on the other (R2 R6 R10)
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  ad;
      logic [15:0] d, ex;
      logic        un, ln;
      {ad, d, un, ln, ex} = VEC[i];
      if (i % 2 == 0) set_a(1'b0, 1'b1, 1'b0, un, ln, ad, d);
      else            set_b(1'b0, 1'b1, 1'b0, un, ln, ad, d);
      tick;
      set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);
      set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);
      tick;
      if (i % 2 == 0) begin
        set_b(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, ad, 16'h0);
        tick;
        check("R2 R6 R10 b_dout table", b_dout, ex);
        check("R6 b_drive table", {14'b0, b_drive}, 16'h3);
      end else begin
        set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, ad, 16'h0);
        tick;
        check("R2 R6 R10 a_dout table", a_dout, ex);
        check("R6 a_drive table", {14'b0, a_drive}, 16'h3);
      end
      set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);
      set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);
      tick;
    end

    // R1: half-enabled writes leave address 20 alone; half-enabled read drives nothing
    set_a(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 16'h1234); tick;
    set_a(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h20, 16'h5678); tick;
    set_a(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h20, 16'h0);    tick;
    check("R1 a_drive deselected read", {14'b0, a_drive}, 16'h0);
    check("R1 a_dout deselected read", a_dout, 16'h0);
    set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);
    set_b(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h20, 16'h0);    tick;
    check("R1 b_dout after deselected writes", b_dout, 16'hFF00);
    set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);

    // R4: both lane selects high: no write, no drive
    set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h10, 16'h0000); tick;
    set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);     tick;
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h10, 16'h0);    tick;
    check("R4 a_drive no lanes", {14'b0, a_drive}, 16'h0);
    set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 16'h0);    tick;
    check("R4 a_dout unchanged", a_dout, 16'hAB66);

    // R3: lower lane only
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h10, 16'h0);    tick;
    check("R3 a_dout lower only", a_dout, 16'h0066);
    check("R3 a_drive lower only", {14'b0, a_drive}, 16'h1);

    // R5: output enable acts between clock edges
    set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 16'h0);    tick;
    a_oe_n = 1'b1; #1;
    check("R5 a_drive oe high", {14'b0, a_drive}, 16'h0);
    check("R5 a_dout oe high", a_dout, 16'h0);
    a_oe_n = 1'b0; #1;
    check("R5 a_dout oe low again", a_dout, 16'hAB66);

    // R11: same-port write then read of the same address
    set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h30, 16'hCAFE); tick;
    set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h30, 16'h0);    tick;
    check("R11 a_dout read after write", a_dout, 16'hCAFE);

    // R8 flow-through: drive stops right after the deselecting edge
    set_a(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30, 16'h0);    tick;
    check("R8 a_drive flow-through deselect", {14'b0, a_drive}, 16'h0);

    // R7 / R8 pipelined on port B
    b_pipe = 1'b1; tick;
    set_b(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h30, 16'h0);    tick;
    check("R7 b_drive not yet", {14'b0, b_drive}, 16'h0);
    set_b(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30, 16'h0);    tick;
    check("R7 b_dout pipelined", b_dout, 16'hCAFE);
    check("R8 b_drive after deselect", {14'b0, b_drive}, 16'h3);
    tick;
    check("R8 b_drive second edge", {14'b0, b_drive}, 16'h0);

    // R9: pipelined lanes follow the selects of the emerging edge
    set_b(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 16'h0);    tick;
    set_b(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h10, 16'h0);    tick;
    check("R9 b_dout lane from late select", b_dout, 16'h0066);
    check("R9 b_drive lane from late select", {14'b0, b_drive}, 16'h1);
    set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0, 16'h0);
    tick; tick;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule